// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Pipeline

This block turns a stream of raw digitized calorimeter samples, one per bunch-crossing clock, into 8-bit trigger primitive words. A writable linearization table maps each raw code to a 10-bit transverse energy in 0.5 GeV steps. Each linearized value is added to the one before it, and the sum saturates at all ones. A peak finder with one crossing of look-ahead decides which crossing receives the energy. The chosen energy is then compressed through a second writable table to 7 bits.

A third table gives a muon flag for each raw code. A delay line holds the flag until the peak decision for the same crossing is ready, and the flag is only kept on a peak crossing. A mask input forces the output word to zero. A clear input flushes the whole pipeline history. A bypass input hands the summed energy to compression without the peak gate. All three tables load through one address/data/strobe port while the pipeline keeps running.

Top module: `trigPrimPipe`

## Requirements
- R1: The lookup tables are written through `lutWrEn`, `lutSel`, `lutAddr` and `lutData`. `lutSel` 0 selects the linearization table (raw code address, 10-bit data). 1 selects the compression table (10-bit address, data bits 6:0). 2 selects the muon table (raw code address, data bit 0). 3 writes nothing. A write changes what a read returns from the next clock edge on. A sample that reads the entry being written in the same edge gets the old contents.
- R2: The crossing energy is the sum of the linearized values of the current and the previous raw sample. A sum above 1023 saturates to 1023.
- R3: Crossing c is a peak when its sum is strictly greater than the sum of crossing c-1 and greater than or equal to the sum of crossing c+1.
- R4: Outside bypass, a crossing that is not a peak presents energy 0 to the compression table, so its output carries the compression table entry at address 0.
- R5: `tpOut[6:0]` is the compression table entry addressed by the selected 10-bit energy.
- R6: `tpOut[7]` is the muon table entry for the later raw sample of the same crossing. It is set only when that crossing is a peak, and this holds in bypass as well.
- R7: With `bypassIn` high in the output edge, the crossing sum goes to the compression table whether or not the crossing is a peak.
- R8: With `maskIn` high in a clock edge, `tpOut` is 0 after that edge.
- R9: With `clearIn` high in a clock edge, `tpOut` is 0 after that edge. Every sample taken up to and including that edge then counts as energy 0 and muon 0 in all later words.
- R10: A raw sample taken at edge n belongs to crossing n. Its word appears on `tpOut` after edge n+3, once the next crossing's sum (taken at edge n+1) is known.
- R11: After reset, `tpOut` is 0 and every table entry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 8 | Raw digitized sample, one per clock |
| maskIn | input | 1 | Forces the output word to zero |
| bypassIn | input | 1 | Skips the peak gate on the energy |
| clearIn | input | 1 | Flushes the pipeline history |
| lutWrEn | input | 1 | Table write strobe |
| lutSel | input | 2 | Table select: 0 linearization, 1 compression, 2 muon |
| lutAddr | input | 10 | Table write address |
| lutData | input | 10 | Table write data |
| tpOut | output | 8 | Trigger primitive: bit 7 muon, bits 6:0 compressed energy |

## Verification
Two functions can collide in one clock edge. The first case is a table write to an entry that a sample reads in that same edge. The bench rewrites a linearization entry while that very code is on `sampleIn`, then presents the code again, and expects the old value first and the new value after. The second case is a clear or a mask landing on a crossing that holds a peak or a muon flag. The bench issues a clear in the middle of a rising pulse and a mask on alternating edges of a random stream. A behavioural model that keeps the histories of samples and sums as plain arrays predicts every word, and the bench compares the output against it on every clock.

// File: rtl/trigPrimPkg.sv
package trigPrimPkg;
  localparam int RAW_W = 8;   // raw sample code width
  localparam int E_W   = 10;  // linearized / summed energy width
  localparam int C_W   = 7;   // compressed energy width
  localparam int TP_W  = C_W + 1;
  localparam int PEAK_AHEAD = 1;            // crossings of look-ahead in the peak finder
  localparam int MU_DLY     = PEAK_AHEAD + 1; // muon stages to meet the centre sum

  localparam logic [1:0] SEL_LIN  = 2'd0;
  localparam logic [1:0] SEL_COMP = 2'd1;
  localparam logic [1:0] SEL_MU   = 2'd2;

  typedef struct packed {
    logic linWe;
    logic compWe;
    logic muWe;
    logic flush;
    logic mask;
    logic bypass;
  } tpCtl_t;
endpackage

// File: rtl/tpLut.sv
module tpLut #(
  parameter int AW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData,
  input  logic [AW-1:0] rAddr,
  output logic [DW-1:0] rData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  assign rData = mem[rAddr];
endmodule

// File: rtl/tpControl.sv
module tpControl
  import trigPrimPkg::*;
(
  input  logic       lutWrEn,
  input  logic [1:0] lutSel,
  input  logic       maskIn,
  input  logic       bypassIn,
  input  logic       clearIn,
  output tpCtl_t     ctl
);
  always_comb begin
    ctl        = '0;
    ctl.linWe  = lutWrEn && (lutSel == SEL_LIN);
    ctl.compWe = lutWrEn && (lutSel == SEL_COMP);
    ctl.muWe   = lutWrEn && (lutSel == SEL_MU);
    ctl.flush  = clearIn;
    ctl.mask   = maskIn;
    ctl.bypass = bypassIn;
  end
endmodule

// File: rtl/tpDatapath.sv
module tpDatapath
  import trigPrimPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tpCtl_t           ctl,
  input  logic [RAW_W-1:0] sampleIn,
  input  logic [E_W-1:0]   lutAddr,
  input  logic [E_W-1:0]   lutData,
  output logic [TP_W-1:0]  tpOut
);
  logic [E_W-1:0] linRd;
  logic           muRd;
  logic [C_W-1:0] compRd;

  logic [E_W-1:0] linA, linA2;
  logic [E_W-1:0] s0, s1, s2;
  logic           muA;
  logic           muDly [MU_DLY];
  logic [E_W:0]   sumRaw;
  logic [E_W-1:0] sumSat;
  logic           peak;
  logic [E_W-1:0] selE;

  tpLut #(.AW(RAW_W), .DW(E_W)) i_linLut (
    .clk(clk), .rstN(rstN), .we(ctl.linWe),
    .wAddr(lutAddr[RAW_W-1:0]), .wData(lutData),
    .rAddr(sampleIn), .rData(linRd)
  );

  tpLut #(.AW(RAW_W), .DW(1)) i_muLut (
    .clk(clk), .rstN(rstN), .we(ctl.muWe),
    .wAddr(lutAddr[RAW_W-1:0]), .wData(lutData[0]),
    .rAddr(sampleIn), .rData(muRd)
  );

  tpLut #(.AW(E_W), .DW(C_W)) i_compLut (
    .clk(clk), .rstN(rstN), .we(ctl.compWe),
    .wAddr(lutAddr), .wData(lutData[C_W-1:0]),
    .rAddr(selE), .rData(compRd)
  );

  // linearization stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linA  <= '0;
      linA2 <= '0;
      muA   <= 1'b0;
    end else if (ctl.flush) begin
      linA  <= '0;
      linA2 <= '0;
      muA   <= 1'b0;
    end else begin
      linA  <= linRd;
      linA2 <= linA;
      muA   <= muRd;
    end
  end

  // two-sample saturating sum
  assign sumRaw = {1'b0, linA} + {1'b0, linA2};
  assign sumSat = sumRaw[E_W] ? {E_W{1'b1}} : sumRaw[E_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0 <= '0;
      s1 <= '0;
      s2 <= '0;
    end else if (ctl.flush) begin
      s0 <= '0;
      s1 <= '0;
      s2 <= '0;
    end else begin
      s0 <= sumSat;
      s1 <= s0;
      s2 <= s1;
    end
  end

  // muon delay line matching the peak look-ahead
  genvar g;
  generate
    for (g = 0; g < MU_DLY; g++) begin : gMuDly
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          muDly[g] <= 1'b0;
        else if (ctl.flush) muDly[g] <= 1'b0;
        else if (g == 0)    muDly[g] <= muA;
        else                muDly[g] <= muDly[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  // peak decision on the centre sum s1
  assign peak = (s1 > s2) && (s1 >= s0);
  assign selE = (peak || ctl.bypass) ? s1 : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       tpOut <= '0;
    else if (ctl.flush || ctl.mask)  tpOut <= '0;
    else                             tpOut <= {muDly[MU_DLY-1] & peak, compRd};
  end

  // R2: the registered sum never drops below either operand
  assert_sum_saturates_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flush |=> (s0 >= $past(linA)) && (s0 >= $past(linA2)));

  // R3: sums shift by one crossing per clock
  assert_sum_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flush |=> (s1 == $past(s0)) && (s2 == $past(s1)));

  // R6: muon bit never appears on a non-peak crossing
  assert_mu_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    !peak |=> !tpOut[TP_W-1]);

  // R6: a peak with a delayed muon flag reaches the output
  assert_mu_passes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (peak && muDly[MU_DLY-1] && !ctl.mask && !ctl.flush) |=> tpOut[TP_W-1]);

  // R8: mask zeroes the output word
  assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mask |=> (tpOut == '0));

  // R9: clear empties the history
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (tpOut == '0) && (s0 == '0) && (s1 == '0) && (linA == '0) && !muA);
endmodule

// File: rtl/trigPrimPipe.sv
module trigPrimPipe
  import trigPrimPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [RAW_W-1:0] sampleIn,
  input  logic             maskIn,
  input  logic             bypassIn,
  input  logic             clearIn,
  input  logic             lutWrEn,
  input  logic [1:0]       lutSel,
  input  logic [E_W-1:0]   lutAddr,
  input  logic [E_W-1:0]   lutData,
  output logic [TP_W-1:0]  tpOut
);
  tpCtl_t ctl;

  tpControl i_ctl (
    .lutWrEn(lutWrEn), .lutSel(lutSel), .maskIn(maskIn),
    .bypassIn(bypassIn), .clearIn(clearIn), .ctl(ctl)
  );

  tpDatapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .lutAddr(lutAddr), .lutData(lutData), .tpOut(tpOut)
  );
endmodule

// File: tb/test_trigPrimPipe.sv
`timescale 1ns/1ps
module test_trigPrimPipe;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sampleIn = '0;
  logic       maskIn = 1'b0, bypassIn = 1'b0, clearIn = 1'b0, lutWrEn = 1'b0;
  logic [1:0] lutSel = 2'd3;
  logic [9:0] lutAddr = '0, lutData = '0;
  logic [7:0] tpOut;

  trigPrimPipe i_trigPrimPipe (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .maskIn(maskIn),
    .bypassIn(bypassIn), .clearIn(clearIn), .lutWrEn(lutWrEn),
    .lutSel(lutSel), .lutAddr(lutAddr), .lutData(lutData), .tpOut(tpOut)
  );

  always #2.5 clk = ~clk;

  int mLin[256], mComp[1024], mMu[256];
  int linH[8192], muH[8192], sH[8192];
  int e = 8;
  int vecs = 0, bad = 0;
  bit done = 0;
  string tag = "R11";

  task automatic check(input int got, input int exp);
    vecs++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got %02h exp %02h at vector %0d", tag, got, exp, vecs);
    end
  endtask

  task automatic step(input int x, input bit m = 0, input bit b = 0, input bit c = 0,
                      input bit we = 0, input int sel = 3, input int addr = 0, input int data = 0);
    int exp, cen, pk, en;
    sampleIn = x[7:0]; maskIn = m; bypassIn = b; clearIn = c;
    lutWrEn = we; lutSel = sel[1:0]; lutAddr = addr[9:0]; lutData = data[9:0];
    @(posedge clk);
    if (c) begin
      linH[e] = 0; linH[e-1] = 0;
      muH[e] = 0; muH[e-1] = 0; muH[e-2] = 0;
      sH[e-1] = 0; sH[e-2] = 0; sH[e-3] = 0;
      exp = 0;
    end else begin
      sH[e-1] = linH[e-1] + linH[e-2];
      if (sH[e-1] > 1023) sH[e-1] = 1023;
      linH[e] = mLin[x];
      muH[e]  = mMu[x];
      cen = sH[e-3];
      pk  = (cen > sH[e-4]) && (cen >= sH[e-2]);
      en  = (b || pk) ? cen : 0;
      exp = m ? 0 : (((muH[e-3] & pk) << 7) | mComp[en]);
    end
    if (we) begin
      if (sel == 0) mLin[addr % 256] = data;
      else if (sel == 1) mComp[addr] = data % 128;
      else if (sel == 2) mMu[addr % 256] = data % 2;
    end
    @(negedge clk);
    check(int'(tpOut), exp);
    e++;
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R11 reset";
    check(int'(tpOut), 0);
    rstN = 1'b1;

    tag = "R1 load";
    for (int a = 0; a < 256; a++) step(0, 0, 0, 0, 1, 0, a, a * 4);
    for (int a = 0; a < 1024; a++) step(0, 0, 0, 0, 1, 1, a, (a * 5 + 1) % 128);
    for (int a = 0; a < 256; a++) step(0, 0, 0, 0, 1, 2, a, (a % 3 == 0) ? 1 : 0);

    tag = "R3 R10 isolated pulse";
    step(0); step(0); step(51); step(0); step(0); step(0); step(0);

    tag = "R3 plateau";
    step(10); step(20); step(20); step(20); step(10); step(0); step(0); step(0); step(0);

    tag = "R2 saturation";
    step(255); step(255); step(255); step(0); step(0); step(0); step(0);

    tag = "R4 falling ramp";
    step(200); step(150); step(100); step(50); step(0); step(0); step(0); step(0);

    tag = "R6 muon stream";
    for (int i = 0; i < 60; i++) step($urandom_range(0, 255));

    tag = "R7 bypass";
    for (int i = 0; i < 30; i++) step($urandom_range(0, 255), 0, 1);
    step(0); step(0); step(0);

    tag = "R8 mask";
    for (int i = 0; i < 20; i++) step($urandom_range(0, 255), i[0]);
    step(0, 1); step(0); step(0); step(0);

    tag = "R9 clear";
    step(30); step(60); step(90, 0, 0, 1); step(60); step(30); step(0); step(0); step(0); step(0);
    step(60); step(3, 0, 0, 1); step(0); step(0); step(0); step(0);

    tag = "R1 live rewrite";
    step(7, 0, 0, 0, 1, 0, 7, 1000); step(0); step(0);
    step(7); step(0); step(0); step(0); step(0);
    step(9, 0, 0, 0, 1, 3, 9, 0); step(0); step(0); step(0); step(0);

    tag = "R5 compression rewrite";
    step(0, 0, 0, 0, 1, 1, 0, 99); step(0); step(0);
    step(40); step(0); step(0); step(0); step(0);

    tag = "R6 muon table rewrite";
    step(0, 0, 0, 0, 1, 2, 41, 1); step(41); step(0); step(0); step(0); step(0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule